// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block sits between a host register port and a single shared ADC that is fronted by a 16-way input multiplexer. It supports three request kinds: a real-time kind started by a hardware strobe, and two software slots started by a register write. Each kind has its own channel bitmap and its own averaging bitmap. When a kind is granted, the sequencer takes a copy of both bitmaps and walks the selected channels from the lowest to the highest. It issues one conversion request per sample. A channel marked for averaging is sampled four times and the truncated mean is stored. All other channels store their single sample.

Results are 10-bit values, left-justified in 16-bit little-endian register pairs. The real-time kind writes a result bank of its own, and the two software slots share a second bank. Each kind sets a status bit when its scan ends. A mask register gates those status bits onto one interrupt line. The host can instead poll the busy and end-of-conversion bits of a slot.

The conversion request toward the ADC is a valid/ready stream. `adc_req_valid` stays high and `adc_req_ch` stays fixed until a cycle in which `adc_req_ready` is high; that cycle is the handshake. Only one conversion is in flight at a time. The ADC must return exactly one `adc_smp_valid` pulse per handshake. A sample that arrives while no conversion is in flight is dropped, so the sample return needs no ready signal.

Top module: `adcseq_top`

## Requirements
- R1: After reset, every control, status and result register reads 0, except the interrupt mask at 0x02, which reads 0x07. `irq` and `adc_req_valid` are low.
- R2: Writing a byte with bit 5 set to a software slot's control register starts that slot. The control register is at 0x10 for slot 1 and at 0x11 for slot 2. On the read after the start write, bit 0 (busy) is 1 and bit 1 (end of conversion) is 0. When the scan ends, the register reads 0x02.
- R3: The scan converts only the channels whose bit is set in the kind's select bitmap, in ascending channel order. The sequencer copies the bitmaps when it grants the kind, so writes made to them during a scan do not change that scan. The select bitmap lives at 0x04+4k (bits 7:0) and 0x05+4k (bits 15:8), with k=0 for real-time, k=1 for slot 1 and k=2 for slot 2.
- R4: A channel whose bit is set in the averaging bitmap (at 0x06+4k and 0x07+4k) gets four conversion requests, and the stored value is the 12-bit sum shifted right by 2, truncated. Any other channel gets one request and stores its sample unchanged.
- R5: The result for channel i is at base+2i (low byte) and base+2i+1 (high byte). The 16-bit word is the 10-bit result shifted left by 6, so its low 6 bits are zero. The real-time bank base is 0x20, and the bank shared by both software slots has base 0x40.
- R6: A start for a kind that is already busy is ignored. It issues no extra requests and leaves busy set.
- R7: A start is ignored while bit 0 of the power register at 0x00 is clear. No kind is granted while that bit is clear.
- R8: When more than one kind is pending, the sequencer serves them in the order real-time, slot 1, slot 2. Each granted kind completes its whole scan before the next kind starts.
- R9: The interrupt status register at 0x01 holds bit 0 for real-time, bit 1 for slot 1 and bit 2 for slot 2. A kind's bit is set when its scan ends, and writing 1 to a bit clears it. The mask register sits at 0x02, and a mask bit of 1 disables that kind. `irq` is the OR of status AND NOT mask.
- R10: While `adc_req_valid` is high and `adc_req_ready` is low, the request stays valid and `adc_req_ch` holds its value.
- R11: The real-time kind is started only by a pulse on `rt_start`, under the same busy and power rules as the software slots. Its status register at 0x12 has the same bit layout as the slot control registers, and a write of bit 5 to that register does nothing.
- R12: A started kind with an empty select bitmap issues no requests. It still completes: end of conversion is set and its status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 8 | Register write address |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | 8 | Register read address |
| reg_rd_data | output | 8 | Register read data (combinational) |
| rt_start | input | 1 | Real-time kind start pulse |
| adc_req_valid | output | 1 | Conversion request valid |
| adc_req_ready | input | 1 | ADC accepts the request |
| adc_req_ch | output | 4 | Channel to convert |
| adc_smp_valid | input | 1 | Sample return pulse |
| adc_smp_data | input | 10 | Sample value |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest situation to reach is arbitration between pending kinds, because all three kinds must be pending at the moment one scan ends. The bench starts a real-time scan with an averaged channel, which keeps the sequencer busy. While that scan runs, the bench starts slot 2 and then slot 1, so that the service order (real-time, slot 1, slot 2) differs from the order of the starts. A second hard case is a rewrite of the select bitmap and a repeated start in the middle of a scan, made while the ADC applies back-pressure. The ADC returns samples close to full scale in that run, so averaging is exercised near the 12-bit limit and the truncation of the mean is visible.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {K_RT = 2'd0, K_S1 = 2'd1, K_S2 = 2'd2} kind_e;
  localparam int NKIND = 3;

  typedef enum logic [2:0] {SC_IDLE, SC_PICK, SC_REQ, SC_WAIT, SC_DONE} scan_e;

  localparam int A_PWR     = 8'h00;
  localparam int A_ISR     = 8'h01;
  localparam int A_IMR     = 8'h02;
  localparam int A_CFG     = 8'h04;  // per kind: sel lo/hi, avg lo/hi; stride 4
  localparam int A_RT_BANK = 8'h20;
  localparam int A_GP_BANK = 8'h40;

  localparam int B_BUSY = 0;
  localparam int B_EOC  = 1;
  localparam int B_GO   = 5;

  function automatic int ctrl_addr(input int k);
    case (k)
      1:       return 8'h10;
      2:       return 8'h11;
      default: return 8'h12;
    endcase
  endfunction
endpackage

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic [AW-1:0]               rd_addr,
  output logic [7:0]                  rd_data,
  input  logic                        rt_start,
  input  logic                        done,
  input  kind_e                       done_kind,
  output logic                        pwr,
  output logic [NKIND-1:0]            pend,
  output logic [NKIND-1:0][NCH-1:0]   sel,
  output logic [NKIND-1:0][NCH-1:0]   avg,
  output logic [NKIND-1:0]            isr,
  output logic [NKIND-1:0]            imr,
  output logic                        irq
);
  logic [NKIND-1:0] eoc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= 1'b0;
      imr <= '1;
    end else if (wr_en) begin
      if (wr_addr == AW'(A_PWR)) pwr <= wr_data[0];
      if (wr_addr == AW'(A_IMR)) imr <= wr_data[NKIND-1:0];
    end
  end

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    localparam int CFG = A_CFG + 4 * k;
    localparam int CTL = ctrl_addr(k);
    logic [NCH-1:0] sel_r, avg_r;
    logic           pend_r, eoc_r, isr_r, go;
    logic           fin;

    if (k == int'(K_RT)) begin : g_hw
      assign go = rt_start;
    end else begin : g_sw
      assign go = wr_en && (wr_addr == AW'(CTL)) && wr_data[B_GO];
    end

    assign fin = done && (done_kind == kind_e'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sel_r  <= '0;
        avg_r  <= '0;
        pend_r <= 1'b0;
        eoc_r  <= 1'b0;
        isr_r  <= 1'b0;
      end else begin
        if (wr_en) begin
          for (int j = 0; j < NCH; j++) begin
            if (wr_addr == AW'(CFG + j / 8))     sel_r[j] <= wr_data[j % 8];
            if (wr_addr == AW'(CFG + 2 + j / 8)) avg_r[j] <= wr_data[j % 8];
          end
        end
        if (fin) begin
          pend_r <= 1'b0;
          eoc_r  <= 1'b1;
        end else if (go && pwr && !pend_r) begin
          pend_r <= 1'b1;
          eoc_r  <= 1'b0;
        end
        if (fin) isr_r <= 1'b1;
        else if (wr_en && wr_addr == AW'(A_ISR) && wr_data[k]) isr_r <= 1'b0;
      end
    end

    assign sel[k]  = sel_r;
    assign avg[k]  = avg_r;
    assign pend[k] = pend_r;
    assign eoc[k]  = eoc_r;
    assign isr[k]  = isr_r;
  end

  assign irq = |(isr & ~imr);

  always_comb begin
    logic [15:0] ws, wa;
    rd_data = '0;
    if (rd_addr == AW'(A_PWR)) rd_data = {7'b0, pwr};
    if (rd_addr == AW'(A_ISR)) rd_data = 8'(isr);
    if (rd_addr == AW'(A_IMR)) rd_data = 8'(imr);
    for (int k = 0; k < NKIND; k++) begin
      ws = 16'(sel[k]);
      wa = 16'(avg[k]);
      if (rd_addr == AW'(A_CFG + 4 * k))     rd_data = ws[7:0];
      if (rd_addr == AW'(A_CFG + 4 * k + 1)) rd_data = ws[15:8];
      if (rd_addr == AW'(A_CFG + 4 * k + 2)) rd_data = wa[7:0];
      if (rd_addr == AW'(A_CFG + 4 * k + 3)) rd_data = wa[15:8];
      if (rd_addr == AW'(ctrl_addr(k))) begin
        rd_data[B_BUSY] = pend[k];
        rd_data[B_EOC]  = eoc[k];
      end
    end
  end
endmodule

// File: rtl/adcseq_scan.sv
module adcseq_scan
  import adcseq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int RES_W    = 10,
  parameter int ACC_W    = 12,
  parameter int AVG_LOG2 = 2,
  localparam int CW      = $clog2(NCH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pwr,
  input  logic [NKIND-1:0]          pend,
  input  logic [NKIND-1:0][NCH-1:0] sel,
  input  logic [NKIND-1:0][NCH-1:0] avg,
  output logic                      adc_req_valid,
  input  logic                      adc_req_ready,
  output logic [CW-1:0]             adc_req_ch,
  input  logic                      adc_smp_valid,
  input  logic [RES_W-1:0]          adc_smp_data,
  output logic                      res_we,
  output kind_e                     res_kind,
  output logic [CW-1:0]             res_ch,
  output logic [RES_W-1:0]          res_val,
  output logic                      done,
  output kind_e                     done_kind,
  output logic                      run
);
  scan_e                state;
  kind_e                kind_q, pick;
  logic [NCH-1:0]       mask_q, avgm_q;
  logic [CW-1:0]        ch_q, low;
  logic                 avg_on_q, last;
  logic [AVG_LOG2-1:0]  cnt_q;
  logic [ACC_W-1:0]     acc_q, sum;

  always_comb begin
    low = '0;
    for (int j = NCH - 1; j >= 0; j--) if (mask_q[j]) low = CW'(j);
  end

  always_comb begin
    if (pend[K_RT])      pick = K_RT;
    else if (pend[K_S1]) pick = K_S1;
    else                 pick = K_S2;
  end

  assign sum  = acc_q + ACC_W'(adc_smp_data);
  assign last = !avg_on_q || (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SC_IDLE;
      kind_q   <= K_RT;
      mask_q   <= '0;
      avgm_q   <= '0;
      ch_q     <= '0;
      avg_on_q <= 1'b0;
      cnt_q    <= '0;
      acc_q    <= '0;
    end else begin
      case (state)
        SC_IDLE: if (pwr && |pend) begin
          kind_q <= pick;
          mask_q <= sel[pick];
          avgm_q <= avg[pick];
          state  <= SC_PICK;
        end
        SC_PICK: if (|mask_q) begin
          ch_q         <= low;
          mask_q[low]  <= 1'b0;
          avg_on_q     <= avgm_q[low];
          cnt_q        <= '0;
          acc_q        <= '0;
          state        <= SC_REQ;
        end else begin
          state <= SC_DONE;
        end
        SC_REQ: if (adc_req_ready) state <= SC_WAIT;
        SC_WAIT: if (adc_smp_valid) begin
          if (last) begin
            state <= SC_PICK;
          end else begin
            acc_q <= sum;
            cnt_q <= cnt_q + 1'b1;
            state <= SC_REQ;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  assign adc_req_valid = (state == SC_REQ);
  assign adc_req_ch    = ch_q;
  assign res_we        = (state == SC_WAIT) && adc_smp_valid && last;
  assign res_kind      = kind_q;
  assign res_ch        = ch_q;
  assign res_val       = avg_on_q ? RES_W'(sum >> AVG_LOG2) : adc_smp_data;
  assign done          = (state == SC_DONE);
  assign done_kind     = kind_q;
  assign run           = (state != SC_IDLE);
endmodule

// File: rtl/adcseq_results.sv
module adcseq_results
  import adcseq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int RES_W = 10,
  parameter int AW    = 8,
  localparam int CW   = $clog2(NCH),
  localparam int PAD  = 16 - RES_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  kind_e            kind,
  input  logic [CW-1:0]    ch,
  input  logic [RES_W-1:0] val,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data,
  output logic             rd_hit
);
  localparam int NBANK = 2;
  logic [RES_W-1:0] bank [NBANK][NCH];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic mine;
    assign mine = (b == 0) ? (kind == K_RT) : (kind != K_RT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NCH; i++) bank[b][i] <= '0;
      end else if (we && mine) begin
        bank[b][ch] <= val;
      end
    end
  end

  always_comb begin
    logic [15:0] w;
    int base;
    rd_data = '0;
    rd_hit  = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      base = (b == 0) ? A_RT_BANK : A_GP_BANK;
      for (int i = 0; i < NCH; i++) begin
        w = {bank[b][i], {PAD{1'b0}}};
        if (rd_addr == AW'(base + 2 * i)) begin
          rd_data = w[7:0];
          rd_hit  = 1'b1;
        end
        if (rd_addr == AW'(base + 2 * i + 1)) begin
          rd_data = w[15:8];
          rd_hit  = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int NCH      = 16,
  parameter int RES_W    = 10,
  parameter int ACC_W    = 12,
  parameter int AVG_LOG2 = 2,
  parameter int AW       = 8,
  localparam int CW      = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [AW-1:0]    reg_wr_addr,
  input  logic [7:0]       reg_wr_data,
  input  logic [AW-1:0]    reg_rd_addr,
  output logic [7:0]       reg_rd_data,
  input  logic             rt_start,
  output logic             adc_req_valid,
  input  logic             adc_req_ready,
  output logic [CW-1:0]    adc_req_ch,
  input  logic             adc_smp_valid,
  input  logic [RES_W-1:0] adc_smp_data,
  output logic             irq
);
  logic                      pwr, done, run, res_we, res_hit;
  logic [NKIND-1:0]          pend, isr, imr;
  logic [NKIND-1:0][NCH-1:0] sel, avg;
  kind_e                     done_kind, res_kind;
  logic [CW-1:0]             res_ch;
  logic [RES_W-1:0]          res_val;
  logic [7:0]                ctl_rd, res_rd;

  adcseq_regs #(.NCH(NCH), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(ctl_rd),
    .rt_start(rt_start), .done(done), .done_kind(done_kind),
    .pwr(pwr), .pend(pend), .sel(sel), .avg(avg),
    .isr(isr), .imr(imr), .irq(irq)
  );

  adcseq_scan #(.NCH(NCH), .RES_W(RES_W), .ACC_W(ACC_W), .AVG_LOG2(AVG_LOG2)) u_scan (
    .clk(clk), .rst_n(rst_n),
    .pwr(pwr), .pend(pend), .sel(sel), .avg(avg),
    .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready), .adc_req_ch(adc_req_ch),
    .adc_smp_valid(adc_smp_valid), .adc_smp_data(adc_smp_data),
    .res_we(res_we), .res_kind(res_kind), .res_ch(res_ch), .res_val(res_val),
    .done(done), .done_kind(done_kind), .run(run)
  );

  adcseq_results #(.NCH(NCH), .RES_W(RES_W), .AW(AW)) u_res (
    .clk(clk), .rst_n(rst_n),
    .we(res_we), .kind(res_kind), .ch(res_ch), .val(res_val),
    .rd_addr(reg_rd_addr), .rd_data(res_rd), .rd_hit(res_hit)
  );

  assign reg_rd_data = res_hit ? res_rd : ctl_rd;
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker
  import adcseq_pkg::*;
#(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_req_valid,
  input logic          adc_req_ready,
  input logic [CW-1:0] adc_req_ch,
  input logic [2:0]    pend,
  input logic [2:0]    isr,
  input logic [2:0]    imr,
  input logic          irq,
  input logic          pwr,
  input logic          run,
  input logic          done,
  input kind_e         done_kind
);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    adc_req_valid && !adc_req_ready |=> adc_req_valid && $stable(adc_req_ch));

  p_serve_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pend[done_kind]);

  p_done_sets_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> isr[$past(done_kind)]);

  p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 3'b111) |-> !irq);

  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend[1] && !(done && done_kind == K_S1) |=> pend[1]);

  p_no_grant_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !pwr |=> !run);
endmodule

bind adcseq_top adcseq_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready), .adc_req_ch(adc_req_ch),
  .pend(pend), .isr(isr), .imr(imr), .irq(irq), .pwr(pwr),
  .run(run), .done(done), .done_kind(done_kind)
);

// File: tb/adcseq_top_bench.sv
module adcseq_top_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_wr_en = 0;
  logic [7:0] reg_wr_addr = 0, reg_wr_data = 0, reg_rd_addr = 0;
  logic [7:0] reg_rd_data;
  logic       rt_start = 0;
  logic       adc_req_valid, adc_req_ready = 1;
  logic [3:0] adc_req_ch;
  logic       adc_smp_valid = 0;
  logic [9:0] adc_smp_data = 0;
  logic       irq;

  int n_chk = 0, n_err = 0;
  int exp_q[$];
  int exp_bank[2][16];
  int bp = 0, smp_mode = 0, acc = 0;

  always #2 clk = ~clk;

  adcseq_top u_adcseq_top (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .rt_start(rt_start),
    .adc_req_valid(adc_req_valid), .adc_req_ready(adc_req_ready), .adc_req_ch(adc_req_ch),
    .adc_smp_valid(adc_smp_valid), .adc_smp_data(adc_smp_data),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_addr = 8'(a); reg_wr_data = 8'(d);
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_rd_addr = 8'(a);
    #1 d = int'(reg_rd_data);
  endtask

  // reference: one queue entry per expected request {kind, avg, index, channel}
  task automatic plan_scan(input int kind, input int sel, input int av);
    for (int ch = 0; ch < 16; ch++)
      if (sel[ch])
        for (int i = 0; i < (av[ch] ? 4 : 1); i++)
          exp_q.push_back((kind << 8) | (av[ch] << 7) | (i << 4) | ch);
  endtask

  task automatic model_sample(input int e, input int smp);
    int b, ch;
    b = (((e >> 8) & 3) == 0) ? 0 : 1;
    ch = e & 15;
    if (((e >> 7) & 1) == 0) exp_bank[b][ch] = smp;
    else begin
      if (((e >> 4) & 7) == 0) acc = 0;
      acc += smp;
      if (((e >> 4) & 7) == 3) exp_bank[b][ch] = acc >> 2;
    end
  endtask

  task automatic cfg(input int kind, input int sel, input int av);
    wr(4 + 4 * kind, sel & 255);
    wr(5 + 4 * kind, sel >> 8);
    wr(6 + 4 * kind, av & 255);
    wr(7 + 4 * kind, av >> 8);
  endtask

  task automatic wait_eoc(input int a, input string tag);
    int d = 0;
    for (int n = 0; n < 3000; n++) begin
      rd(a, d);
      if (d[1] && !d[0]) break;
    end
    chk(tag, d & 3, 2);
  endtask

  task automatic check_bank(input int b, input string tag);
    int lo, hi, w;
    for (int ch = 0; ch < 16; ch++) begin
      rd((b == 0 ? 32 : 64) + 2 * ch, lo);
      rd((b == 0 ? 32 : 64) + 2 * ch + 1, hi);
      w = (hi << 8) | lo;
      chk({tag, " R5 result value"}, w >> 6, exp_bank[b][ch]);
      chk("R5 low six bits zero", w & 63, 0);
    end
  endtask

  task automatic finish_sim;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // behavioural ADC stand-in and per-clock request stream comparison
  initial begin
    int prev_vld = 0, prev_rdy = 0, prev_ch = 0, delay = 0, cur_e = 0, k = 0, cyc = 0, smp;
    forever begin
      @(negedge clk);
      cyc++;
      adc_smp_valid = 0;
      if (prev_vld && prev_rdy) begin
        if (exp_q.size() == 0) chk("R3 R8 R6 unexpected request", prev_ch, -1);
        else begin
          cur_e = exp_q.pop_front();
          chk("R3 R8 channel order", prev_ch, cur_e & 15);
          delay = 1 + k % 3;
        end
      end else if (prev_vld) begin
        chk("R10 valid held", int'(adc_req_valid), 1);
        chk("R10 channel held", int'(adc_req_ch), prev_ch);
      end
      if (delay > 0) begin
        delay--;
        if (delay == 0) begin
          smp = smp_mode ? (1023 - k % 3) : (((cur_e & 15) * 37 + k * 11 + 5) & 1023);
          k++;
          adc_smp_valid = 1;
          adc_smp_data = 10'(smp);
          model_sample(cur_e, smp);
        end
      end
      adc_req_ready = bp ? (cyc % 3 == 2) : 1'b1;
      prev_vld = int'(adc_req_valid);
      prev_rdy = int'(adc_req_ready);
      prev_ch = int'(adc_req_ch);
    end
  end

  initial begin
    #(4 * 100000);
    n_chk++; n_err++;
    $display("FAIL watchdog R2 completion: actual 1 expected 0");
    finish_sim();
  end

  initial begin
    int d;
    for (int b = 0; b < 2; b++) for (int c = 0; c < 16; c++) exp_bank[b][c] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h10, d); chk("R1 slot1 ctrl", d, 0);
    rd(8'h12, d); chk("R1 rt status", d, 0);
    rd(8'h01, d); chk("R1 isr", d, 0);
    rd(8'h02, d); chk("R1 imr", d, 7);
    rd(8'h40, d); chk("R1 result", d, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 req valid", int'(adc_req_valid), 0);

    // R7 start without power is ignored
    cfg(1, 16'h0001, 0);
    wr(8'h10, 8'h20);
    repeat (20) @(negedge clk);
    rd(8'h10, d); chk("R7 start ignored unpowered", d, 0);

    // R2 R3 R4 R5 basic slot-1 scan with one averaged channel
    wr(8'h00, 1);
    cfg(1, 16'h8421, 16'h0020);
    plan_scan(1, 16'h8421, 16'h0020);
    wr(8'h10, 8'h20);
    rd(8'h10, d); chk("R2 busy after start", d & 3, 1);
    wait_eoc(8'h10, "R2 slot1 end of conversion");
    chk("R3 all requests issued", exp_q.size(), 0);
    check_bank(1, "R4");
    rd(8'h01, d); chk("R9 isr slot1", d, 2);
    chk("R9 irq masked", int'(irq), 0);
    wr(8'h02, 0);
    #1 chk("R9 irq unmasked", int'(irq), 1);
    wr(8'h01, 2);
    #1 chk("R9 irq after clear", int'(irq), 0);
    rd(8'h01, d); chk("R9 isr write-one-clear", d, 0);

    // R3 R4 R6 R10 slot 2 under back-pressure, near full scale
    bp = 1; smp_mode = 1;
    cfg(2, 16'h00F0, 16'h00F0);
    plan_scan(2, 16'h00F0, 16'h00F0);
    wr(8'h11, 8'h20);
    wr(8'h0C, 8'hFF);
    wr(8'h0D, 8'hFF);
    wr(8'h11, 8'h20);
    rd(8'h11, d); chk("R6 busy after repeat start", d & 1, 1);
    wait_eoc(8'h11, "R2 slot2 end of conversion");
    chk("R6 no extra requests", exp_q.size(), 0);
    check_bank(1, "R4 truncated average");
    bp = 0; smp_mode = 0;

    // R11 write to real-time status does nothing
    wr(8'h12, 8'h20);
    repeat (10) @(negedge clk);
    rd(8'h12, d); chk("R11 write does not start", d, 0);

    // R8 arbitration real-time > slot1 > slot2
    wr(8'h01, 7);
    cfg(0, 16'h0003, 16'h0001);
    cfg(1, 16'h3000, 0);
    cfg(2, 16'h0C00, 0);
    plan_scan(0, 16'h0003, 16'h0001);
    plan_scan(1, 16'h3000, 0);
    plan_scan(2, 16'h0C00, 0);
    @(negedge clk); rt_start = 1;
    @(negedge clk); rt_start = 0;
    wr(8'h11, 8'h20);
    wr(8'h10, 8'h20);
    rd(8'h12, d); chk("R11 rt busy", d & 1, 1);
    wait_eoc(8'h11, "R8 slot2 completes last");
    rd(8'h12, d); chk("R11 rt done", d, 2);
    rd(8'h10, d); chk("R8 slot1 done", d, 2);
    chk("R8 all requests issued", exp_q.size(), 0);
    check_bank(0, "R11 rt bank");
    check_bank(1, "R8 shared bank");
    rd(8'h01, d); chk("R9 isr all kinds", d, 7);
    wr(8'h01, 7);

    // R12 empty bitmap
    cfg(1, 0, 0);
    wr(8'h10, 8'h20);
    wait_eoc(8'h10, "R12 empty scan completes");
    rd(8'h01, d); chk("R12 isr set", d, 2);
    #1 chk("R12 irq", int'(irq), 1);
    wr(8'h02, 2);
    #1 chk("R9 irq masked again", int'(irq), 0);
    chk("R12 no requests", exp_q.size(), 0);

    repeat (5) @(negedge clk);
    finish_sim();
  end
endmodule